// File: doc/BRIEF.md
# Dual-Address I2C Slave

This block is an I2C target that responds to two separately programmed addresses, called channel A and channel B. Each channel has its own enable, its own address setting, a one-byte receive holding register and a one-byte transmit holding register. The block samples SCL and SDA through synchronizers and finds START and STOP conditions. It shifts in the address byte and acknowledges it when an enabled channel matches. It then either captures written bytes into that channel's receive register or shifts out that channel's transmit register.

Channel A compares only the upper five address bits, so it answers a block of four consecutive addresses. The two low bits the host actually sent are reported on a status output. Channel B compares all seven bits. Each channel raises flags that mark three things: a received byte is waiting, the transmit register has been consumed and needs refilling, and the channel's address was matched. Each channel also marks whether its latest received byte was the first data byte of the transfer, which is normally a word address. Bus-level status reports three things: a transfer is in progress between START and STOP, the direction of the current transfer, and whether the host refused the last transmitted byte.

Top module: `i2c_dual_slave`

## Requirements
- R1: `busActive` becomes 1 after a START condition (SDA falls while SCL is high) and returns to 0 after a STOP condition (SDA rises while SCL is high). It is 0 after reset.
- R2: With `enA`=1, channel A acknowledges any address byte whose upper five address bits equal `addrAHi`. `aLowBits` then holds the two lowest address bits the host sent.
- R3: With `enB`=1, channel B acknowledges only an address byte whose seven address bits all equal `addrB`.
- R4: A channel whose enable is 0 never acknowledges its address. `matchA`/`matchB` are set only on an acknowledged match of that channel. They are cleared by a one-cycle pulse on `matchClrA`/`matchClrB`.
- R5: During a write transfer, each byte received after the address is placed on that channel's `rxData` output and sets its `rxFlag`. A one-cycle `rxRd` pulse clears the flag.
- R6: `wordAddrA`/`wordAddrB` is 1 when the byte in that channel's receive register is the first data byte after the address byte. It is 0 for every later byte of the same transfer.
- R7: During a read transfer, the channel's transmit register is sent MSB first. Each time the register is loaded into the shifter, that channel's `txFlag` is set. A one-cycle `txWr` pulse writes the register and clears the flag.
- R8: `slaveTx` takes the R/W bit (address byte bit 0) of the last acknowledged address: 1 for a read, which is slave transmit, and 0 for a write.
- R9: `hostNack` is 1 after the host answers a transmitted byte with NACK (SDA high on the ninth clock). The block then stops driving SDA until the next START.
- R10: `sdaOe` (1 means pull SDA low) changes only while synchronized SCL is low, and is 0 whenever `busActive` is 0.
- R11: When an address byte matches both enabled channels, channel A takes the transfer and only `matchA` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | SCL line as seen on the pad |
| sdaIn | input | 1 | SDA line as seen on the pad |
| sdaOe | output | 1 | 1 pulls SDA low (open-drain enable) |
| enA | input | 1 | Channel A enable |
| addrAHi | input | 5 | Channel A address, upper five bits |
| enB | input | 1 | Channel B enable |
| addrB | input | 7 | Channel B full 7-bit address |
| txDataA | input | 8 | Data for channel A transmit register |
| txWrA | input | 1 | Write strobe for channel A transmit register |
| txDataB | input | 8 | Data for channel B transmit register |
| txWrB | input | 1 | Write strobe for channel B transmit register |
| rxRdA | input | 1 | Read acknowledge for channel A receive register |
| rxRdB | input | 1 | Read acknowledge for channel B receive register |
| matchClrA | input | 1 | Clears matchA |
| matchClrB | input | 1 | Clears matchB |
| rxDataA | output | 8 | Channel A receive register |
| rxDataB | output | 8 | Channel B receive register |
| rxFlagA | output | 1 | Channel A received byte waiting |
| rxFlagB | output | 1 | Channel B received byte waiting |
| txFlagA | output | 1 | Channel A transmit register needs refilling |
| txFlagB | output | 1 | Channel B transmit register needs refilling |
| matchA | output | 1 | Channel A address matched |
| matchB | output | 1 | Channel B address matched |
| wordAddrA | output | 1 | Channel A receive byte is the first data byte |
| wordAddrB | output | 1 | Channel B receive byte is the first data byte |
| aLowBits | output | 2 | Low two address bits received by channel A |
| slaveTx | output | 1 | Direction of current transfer, 1 = slave transmit |
| hostNack | output | 1 | Host refused last transmitted byte |
| busActive | output | 1 | Bus between START and STOP |

## Verification
The address decoder is swept over all 128 addresses, with alternating R/W bits, against channel A at 0x50 (which covers 0x50–0x53) and channel B at 0x3C. This separates the masked match from the full match and shows that `aLowBits` and `slaveTx` follow what the host sent. Further probes put channel B inside channel A's block to exercise priority, and clear each enable to show that a matching address then goes unanswered. A three-byte write tells the first data byte from later ones through the word-address flag. A three-byte read shows the transmit register being reused until software refills it, and ends with a host NACK.

// File: rtl/i2cds_pkg.sv
package i2cds_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_RX,
    ST_RACK,
    ST_TX,
    ST_TACK
  } slvState_t;

  // Strobes and levels passed from the control FSM to the datapath.
  typedef struct packed {
    logic shiftIn;
    logic shiftOut;
    logic addrHit;
    logic storeRx;
    logic loadTx;
    logic sampleAck;
    logic drvAck;
    logic drvData;
    logic chanB;
    logic firstByte;
  } strobe_t;

endpackage

// File: rtl/i2cds_dp.sv
module i2cds_dp
  import i2cds_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int A_IGNORE    = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       sclIn,
  input  logic                       sdaIn,
  input  logic                       enA,
  input  logic [ADDR_W-A_IGNORE-1:0] addrAHi,
  input  logic                       enB,
  input  logic [ADDR_W-1:0]          addrB,
  input  logic [DATA_W-1:0]          txDataA,
  input  logic                       txWrA,
  input  logic [DATA_W-1:0]          txDataB,
  input  logic                       txWrB,
  input  logic                       rxRdA,
  input  logic                       rxRdB,
  input  logic                       matchClrA,
  input  logic                       matchClrB,
  input  strobe_t                    stb,
  output logic                       evStart,
  output logic                       evStop,
  output logic                       sclRise,
  output logic                       sclFall,
  output logic                       sclHigh,
  output logic                       hitA,
  output logic                       hitB,
  output logic                       rwReq,
  output logic                       sdaOe,
  output logic [DATA_W-1:0]          rxDataA,
  output logic [DATA_W-1:0]          rxDataB,
  output logic [1:0]                 rxFlag,
  output logic [1:0]                 txFlag,
  output logic [1:0]                 matchFlag,
  output logic [1:0]                 wordAddr,
  output logic [A_IGNORE-1:0]        aLowBits,
  output logic                       slaveTx,
  output logic                       hostNack
);

  localparam int A_HI_W = ADDR_W - A_IGNORE;

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclPrev, sdaPrev, sdaNow;
  logic [DATA_W-1:0] shReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclSync[SYNC_STAGES-1];
      sdaPrev <= sdaSync[SYNC_STAGES-1];
    end
  end

  assign sclHigh = sclSync[SYNC_STAGES-1];
  assign sdaNow  = sdaSync[SYNC_STAGES-1];
  assign sclRise = sclHigh & ~sclPrev;
  assign sclFall = ~sclHigh & sclPrev;
  assign evStart = sclHigh & sclPrev & sdaPrev & ~sdaNow;
  assign evStop  = sclHigh & sclPrev & ~sdaPrev & sdaNow;

  // Address decode from the assembled address byte
  assign rwReq = shReg[0];
  assign hitA  = enA && (shReg[DATA_W-1 -: A_HI_W] == addrAHi);
  assign hitB  = enB && (shReg[DATA_W-1:1] == addrB);

  // Per-channel registers
  logic [DATA_W-1:0] txBuf [2];
  logic [DATA_W-1:0] rxBuf [2];
  logic [DATA_W-1:0] txDataIn [2];
  logic [1:0] txWrIn, rxRdIn, matchClrIn;

  assign txDataIn[0] = txDataA;
  assign txDataIn[1] = txDataB;
  assign txWrIn      = {txWrB, txWrA};
  assign rxRdIn      = {rxRdB, rxRdA};
  assign matchClrIn  = {matchClrB, matchClrA};

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    logic sel;
    assign sel = (stb.chanB == (ch == 1));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        txBuf[ch]     <= '0;
        rxBuf[ch]     <= '0;
        rxFlag[ch]    <= 1'b0;
        txFlag[ch]    <= 1'b0;
        matchFlag[ch] <= 1'b0;
        wordAddr[ch]  <= 1'b0;
      end else begin
        if (txWrIn[ch]) txBuf[ch] <= txDataIn[ch];

        if (stb.storeRx && sel) begin
          rxBuf[ch]    <= shReg;
          rxFlag[ch]   <= 1'b1;
          wordAddr[ch] <= stb.firstByte;
        end else if (rxRdIn[ch]) begin
          rxFlag[ch] <= 1'b0;
        end

        if (stb.loadTx && sel)  txFlag[ch] <= 1'b1;
        else if (txWrIn[ch])    txFlag[ch] <= 1'b0;

        if (stb.addrHit && sel) matchFlag[ch] <= 1'b1;
        else if (matchClrIn[ch]) matchFlag[ch] <= 1'b0;
      end
    end
  end

  assign rxDataA = rxBuf[0];
  assign rxDataB = rxBuf[1];

  // Shifter and bus status
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg    <= '0;
      aLowBits <= '0;
      slaveTx  <= 1'b0;
      hostNack <= 1'b0;
    end else begin
      if (stb.loadTx)        shReg <= txBuf[stb.chanB];
      else if (stb.shiftOut) shReg <= {shReg[DATA_W-2:0], 1'b0};
      else if (stb.shiftIn)  shReg <= {shReg[DATA_W-2:0], sdaNow};

      if (stb.addrHit) begin
        slaveTx <= shReg[0];
        if (!stb.chanB) aLowBits <= shReg[A_IGNORE:1];
      end
      if (stb.sampleAck) hostNack <= sdaNow;
    end
  end

  assign sdaOe = stb.drvAck | (stb.drvData & ~shReg[DATA_W-1]);

endmodule

// File: rtl/i2cds_ctrl.sv
module i2cds_ctrl
  import i2cds_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    evStart,
  input  logic    evStop,
  input  logic    sclRise,
  input  logic    sclFall,
  input  logic    hitA,
  input  logic    hitB,
  input  logic    rwReq,
  input  logic    hostNack,
  output strobe_t stb,
  output logic    busActive
);

  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  slvState_t state;
  logic [CNT_W-1:0] bitCnt;
  logic chanReg, rwBit, firstReg;
  logic byteDone;

  assign byteDone = sclFall && (bitCnt == FULL);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      chanReg   <= 1'b0;
      rwBit     <= 1'b0;
      firstReg  <= 1'b0;
      busActive <= 1'b0;
    end else if (evStop) begin
      state     <= ST_IDLE;
      busActive <= 1'b0;
    end else if (evStart) begin
      state     <= ST_ADDR;
      bitCnt    <= '0;
      busActive <= 1'b1;
    end else begin
      unique case (state)
        ST_ADDR: begin
          if (sclRise) bitCnt <= bitCnt + 1'b1;
          else if (byteDone) begin
            if (hitA || hitB) begin
              state   <= ST_AACK;
              chanReg <= !hitA;
              rwBit   <= rwReq;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_AACK: if (sclFall) begin
          bitCnt   <= '0;
          firstReg <= 1'b1;
          state    <= rwBit ? ST_TX : ST_RX;
        end
        ST_RX: begin
          if (sclRise) bitCnt <= bitCnt + 1'b1;
          else if (byteDone) begin
            state    <= ST_RACK;
            firstReg <= 1'b0;
          end
        end
        ST_RACK: if (sclFall) begin
          bitCnt <= '0;
          state  <= ST_RX;
        end
        ST_TX: if (sclFall) begin
          if (bitCnt == LAST) state <= ST_TACK;
          else bitCnt <= bitCnt + 1'b1;
        end
        ST_TACK: if (sclFall) begin
          bitCnt <= '0;
          state  <= hostNack ? ST_IDLE : ST_TX;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    stb           = '0;
    stb.chanB     = (state == ST_ADDR) ? !hitA : chanReg;
    stb.firstByte = firstReg;
    stb.shiftIn   = sclRise && (state == ST_ADDR || state == ST_RX);
    stb.addrHit   = (state == ST_ADDR) && byteDone && (hitA || hitB);
    stb.storeRx   = (state == ST_RX) && byteDone;
    stb.loadTx    = sclFall && (((state == ST_AACK) && rwBit) ||
                                ((state == ST_TACK) && !hostNack));
    stb.shiftOut  = (state == ST_TX) && sclFall;
    stb.sampleAck = (state == ST_TACK) && sclRise;
    stb.drvAck    = (state == ST_AACK) || (state == ST_RACK);
    stb.drvData   = (state == ST_TX);
  end

endmodule

// File: rtl/i2c_dual_slave.sv
module i2c_dual_slave
  import i2cds_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int A_IGNORE    = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       sclIn,
  input  logic                       sdaIn,
  output logic                       sdaOe,
  input  logic                       enA,
  input  logic [ADDR_W-A_IGNORE-1:0] addrAHi,
  input  logic                       enB,
  input  logic [ADDR_W-1:0]          addrB,
  input  logic [DATA_W-1:0]          txDataA,
  input  logic                       txWrA,
  input  logic [DATA_W-1:0]          txDataB,
  input  logic                       txWrB,
  input  logic                       rxRdA,
  input  logic                       rxRdB,
  input  logic                       matchClrA,
  input  logic                       matchClrB,
  output logic [DATA_W-1:0]          rxDataA,
  output logic [DATA_W-1:0]          rxDataB,
  output logic                       rxFlagA,
  output logic                       rxFlagB,
  output logic                       txFlagA,
  output logic                       txFlagB,
  output logic                       matchA,
  output logic                       matchB,
  output logic                       wordAddrA,
  output logic                       wordAddrB,
  output logic [A_IGNORE-1:0]        aLowBits,
  output logic                       slaveTx,
  output logic                       hostNack,
  output logic                       busActive
);

  strobe_t stbW;
  logic evStart, evStop, sclRise, sclFall, sclHigh;
  logic hitA, hitB, rwReq;
  logic [1:0] rxFlag, txFlag, matchFlag, wordAddr;

  i2cds_ctrl #(.DATA_W(DATA_W)) ctrl_i (
    .clk, .rstN, .evStart, .evStop, .sclRise, .sclFall,
    .hitA, .hitB, .rwReq, .hostNack, .stb(stbW), .busActive
  );

  i2cds_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .SYNC_STAGES(SYNC_STAGES), .A_IGNORE(A_IGNORE)
  ) dp_i (
    .clk, .rstN, .sclIn, .sdaIn, .enA, .addrAHi, .enB, .addrB,
    .txDataA, .txWrA, .txDataB, .txWrB, .rxRdA, .rxRdB,
    .matchClrA, .matchClrB, .stb(stbW),
    .evStart, .evStop, .sclRise, .sclFall, .sclHigh,
    .hitA, .hitB, .rwReq, .sdaOe, .rxDataA, .rxDataB,
    .rxFlag, .txFlag, .matchFlag, .wordAddr,
    .aLowBits, .slaveTx, .hostNack
  );

  assign rxFlagA   = rxFlag[0];
  assign rxFlagB   = rxFlag[1];
  assign txFlagA   = txFlag[0];
  assign txFlagB   = txFlag[1];
  assign matchA    = matchFlag[0];
  assign matchB    = matchFlag[1];
  assign wordAddrA = wordAddr[0];
  assign wordAddrB = wordAddr[1];

endmodule

// File: rtl/i2cds_chk.sv
module i2cds_chk
  import i2cds_pkg::*;
(
  input logic    clk,
  input logic    rstN,
  input logic    sdaOe,
  input logic    busActive,
  input logic    sclHigh,
  input logic    enA,
  input logic    enB,
  input logic    matchA,
  input logic    matchB,
  input logic    rxFlagA,
  input logic    rxRdA,
  input logic    txFlagA,
  input logic    txWrA,
  input strobe_t stb
);

  a_r4_match_a_enabled: assert property (@(posedge clk) disable iff (!rstN)
    $rose(matchA) |-> enA);

  a_r4_match_b_enabled: assert property (@(posedge clk) disable iff (!rstN)
    $rose(matchB) |-> enB);

  a_r5_rx_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (rxRdA && !stb.storeRx) |=> !rxFlagA);

  a_r7_tx_write_clears: assert property (@(posedge clk) disable iff (!rstN)
    (txWrA && !stb.loadTx) |=> !txFlagA);

  a_r10_idle_no_drive: assert property (@(posedge clk) disable iff (!rstN)
    !busActive |-> !sdaOe);

  a_r10_change_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclHigh);

endmodule

bind i2c_dual_slave i2cds_chk chk_i (
  .clk(clk), .rstN(rstN), .sdaOe(sdaOe), .busActive(busActive),
  .sclHigh(sclHigh), .enA(enA), .enB(enB), .matchA(matchA), .matchB(matchB),
  .rxFlagA(rxFlagA), .rxRdA(rxRdA), .txFlagA(txFlagA), .txWrA(txWrA),
  .stb(stbW)
);

// File: tb/i2c_dual_slave_tb_top.sv
`timescale 1ns/1ps
module i2c_dual_slave_tb_top;

  localparam int Q = 10;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN;
  logic sclM, sdaM;
  logic sdaOe, sdaBus;
  logic enA, enB;
  logic [4:0] addrAHi;
  logic [6:0] addrB;
  logic [7:0] txDataA, txDataB, rxDataA, rxDataB;
  logic txWrA, txWrB, rxRdA, rxRdB, matchClrA, matchClrB;
  logic rxFlagA, rxFlagB, txFlagA, txFlagB, matchA, matchB;
  logic wordAddrA, wordAddrB, slaveTx, hostNack, busActive;
  logic [1:0] aLowBits;

  assign sdaBus = sdaM & ~sdaOe;

  i2c_dual_slave dut_i (
    .clk, .rstN, .sclIn(sclM), .sdaIn(sdaBus), .sdaOe,
    .enA, .addrAHi, .enB, .addrB,
    .txDataA, .txWrA, .txDataB, .txWrB, .rxRdA, .rxRdB,
    .matchClrA, .matchClrB, .rxDataA, .rxDataB,
    .rxFlagA, .rxFlagB, .txFlagA, .txFlagB, .matchA, .matchB,
    .wordAddrA, .wordAddrB, .aLowBits, .slaveTx, .hostNack, .busActive
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic startCond();
    sdaM = 1'b1; sclM = 1'b1; waitQ();
    sdaM = 1'b0; waitQ();
    sclM = 1'b0; waitQ();
  endtask

  task automatic stopCond();
    sdaM = 1'b0; waitQ();
    sclM = 1'b1; waitQ();
    sdaM = 1'b1; waitQ(); waitQ();
  endtask

  task automatic writeBit(input logic b);
    sdaM = b; waitQ();
    sclM = 1'b1; waitQ(); waitQ();
    sclM = 1'b0; waitQ();
  endtask

  task automatic readBit(output logic b);
    sdaM = 1'b1; waitQ();
    sclM = 1'b1; waitQ();
    b = sdaBus; waitQ();
    sclM = 1'b0; waitQ();
  endtask

  task automatic writeByte(input logic [7:0] d, output logic acked);
    logic a;
    for (int i = 7; i >= 0; i--) writeBit(d[i]);
    readBit(a);
    acked = ~a;
  endtask

  task automatic readByte(input logic ackIt, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin readBit(b); d[i] = b; end
    writeBit(~ackIt);
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1;
    @(negedge clk); s = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] d;
    rstN = 0; sclM = 1; sdaM = 1;
    enA = 1; enB = 1; addrAHi = 5'h14; addrB = 7'h3C;
    txDataA = 8'hFF; txDataB = 8'hFF;
    txWrA = 0; txWrB = 0; rxRdA = 0; rxRdB = 0; matchClrA = 0; matchClrB = 0;
    repeat (5) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check(!busActive && !sdaOe && !matchA && !matchB && !rxFlagA && !txFlagB,
          "reset R1 R10", {busActive, sdaOe, matchA, matchB}, 0);
    pulse(txWrA); pulse(txWrB);

    // R2 R3 R8 sweep over every address, R/W alternating
    for (int a = 0; a < 128; a++) begin
      bit expA, expB;
      expA = (a >> 2) == 5'h14;
      expB = (a == 7'h3C) && !expA;
      startCond();
      check(busActive == 1'b1, "R1 start", busActive, 1);
      writeByte({a[6:0], a[0]}, ack);
      check(ack == (expA || expB), "R2 R3 ack sweep", ack, expA || expB);
      stopCond();
      check(busActive == 1'b0, "R1 stop", busActive, 0);
      check(matchA == expA && matchB == expB, "R4 match flags",
            {matchA, matchB}, {expA, expB});
      if (expA) check(aLowBits == a[1:0], "R2 low bits", aLowBits, a & 3);
      if (expA || expB) check(slaveTx == a[0], "R8 direction", slaveTx, a & 1);
      pulse(matchClrA); pulse(matchClrB);
      check(!matchA && !matchB, "R4 match clear", {matchA, matchB}, 0);
    end

    // R11 priority: B inside A's block
    addrB = 7'h51;
    startCond(); writeByte({7'h51, 1'b0}, ack); stopCond();
    check(ack, "R11 ack", ack, 1);
    check(matchA && !matchB, "R11 priority", {matchA, matchB}, 2'b10);
    pulse(matchClrA); pulse(matchClrB);
    addrB = 7'h3C;

    // R4 disabled channels
    enA = 0;
    startCond(); writeByte({7'h50, 1'b0}, ack); stopCond();
    check(!ack && !matchA, "R4 A disabled", {ack, matchA}, 0);
    enA = 1; enB = 0;
    startCond(); writeByte({7'h3C, 1'b0}, ack); stopCond();
    check(!ack && !matchB, "R4 B disabled", {ack, matchB}, 0);
    enB = 1;

    // R5 R6 three-byte write to A
    pulse(rxRdA);
    startCond(); writeByte({7'h52, 1'b0}, ack);
    writeByte(8'h10, ack);
    check(ack, "R5 data ack", ack, 1);
    check(rxFlagA && rxDataA == 8'h10, "R5 byte1", rxDataA, 8'h10);
    check(wordAddrA == 1'b1, "R6 first byte", wordAddrA, 1);
    pulse(rxRdA);
    check(!rxFlagA, "R5 read clears", rxFlagA, 0);
    writeByte(8'hA5, ack);
    check(rxFlagA && rxDataA == 8'hA5, "R5 byte2", rxDataA, 8'hA5);
    check(wordAddrA == 1'b0, "R6 later byte", wordAddrA, 0);
    writeByte(8'h3C, ack);
    check(rxDataA == 8'h3C && !wordAddrA && !rxFlagB, "R5 byte3", rxDataA, 8'h3C);
    stopCond();

    // R7 R9 three-byte read from B
    txDataB = 8'h96; pulse(txWrB);
    check(!txFlagB, "R7 write clears", txFlagB, 0);
    startCond(); writeByte({7'h3C, 1'b1}, ack);
    check(ack && slaveTx, "R8 read ack", {ack, slaveTx}, 2'b11);
    readByte(1'b1, d);
    check(d == 8'h96, "R7 byte1", d, 8'h96);
    check(txFlagB, "R7 flag set", txFlagB, 1);
    txDataB = 8'h3A; pulse(txWrB);
    check(!txFlagB, "R7 flag clear", txFlagB, 0);
    readByte(1'b1, d);
    check(d == 8'h96 && !hostNack, "R7 byte2 reused", d, 8'h96);
    readByte(1'b0, d);
    check(d == 8'h3A, "R7 byte3 refilled", d, 8'h3A);
    check(hostNack && !sdaOe, "R9 host nack", {hostNack, sdaOe}, 2'b10);
    stopCond();
    check(!busActive && !sdaOe, "R10 idle release", {busActive, sdaOe}, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule